// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block drives the multiplexed external memory bus of an 8-bit controller core. Each machine cycle is cut into twelve slots. The block places the address latch strobe, the program store strobe and the read and write strobes in fixed slot windows. It also drives the low address/data port and the high address port. The core issues code-fetch requests and data-memory read or write requests. The block accepts each request at a cycle boundary, runs the matching bus pattern, and signals completion.

A code fetch goes either to internal program memory, with no program store strobe, or out on the bus. The choice depends on the access-enable pin, sampled once as reset is released, and on the fetch address. A suppression input keeps the address latch strobe quiet except during data accesses. A rate input selects the fast mode. In that mode the slot counter moves two slots per clock, so every strobe width and the machine cycle itself are halved.

Top module: `ebus_seq`

## Requirements
- R1: With no data access under way and suppression off, `ale` is high in slots 0-1 and 6-7 of every machine cycle. That is two pulses of two clocks each in normal rate.
- R2: A data access takes one whole machine cycle starting at slot 0. In that cycle `ale` pulses only in slots 0-1, the slot 6-7 pulse is skipped, and `psen_n` stays high throughout.
- R3: An external code fetch drives `psen_n` low in slots 2-5 (first half) or 8-11 (second half). With a fetch request held high there are two pulses per machine cycle. `fetch_done` is high in the last low slot, and `rdata` equals `ad_in` there.
- R4: When the latched access-enable is 1 and the fetch address is below INT_CODE_BYTES (default 8192), `psen_n` stays high, `code_internal` is 1 and `fetch_done` still comes in the last slot of the window. Address 0x1FFF is internal and 0x2000 is external.
- R5: When the latched access-enable is 0, every fetch is external, whatever its address.
- R6: `ea_pin` is captured while `rst_n` is low. Changes after reset release have no effect.
- R7: With `ale_off` = 1, `ale` is high only in slots 0-1 of a data access cycle.
- R8: `rd_n` or `wr_n` is low in slots 4-9 of a data cycle, which is six clocks at normal rate. `data_done` is high in the last low slot, and for a read `rdata` equals `ad_in` there.
- R9: While a strobe is active, `a_hi` carries the fetch address high byte for an external fetch. It carries the data address high byte for a data access with `data_wide` = 1, and `p2_reg` for one with `data_wide` = 0.
- R10: In the address slots of an external access (slots where `ale` marks it), `ad_oe` is 1 and `ad_out` is the low address byte. During a write, `ad_oe` is 1 with `ad_out` = write data while `wr_n` is low. During a read, `ad_oe` is 0 while `rd_n` is low.
- R11: With `six_clk` = 1 the slot counter advances two even slots per clock. A machine cycle is then six clocks, an `ale` pulse one clock and a read strobe three clocks.
- R12: A data request is accepted only as slot 0 begins, and it wins over a pending fetch there. A fetch is accepted as slot 0 or slot 6 begins when no data cycle holds the bus. `data_acc` and `fetch_acc` are high in the cycle before the window starts.
- R13: After reset the slot counter rests in slot 11 with all strobes inactive: `ale` = 0, `psen_n` = `rd_n` = `wr_n` = 1, `ad_oe` = 0, no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ea_pin | input | 1 | Access-enable pin, captured during reset |
| adv_en | input | 1 | Slot advance enable |
| six_clk | input | 1 | 1 = fast rate, two slots per clock |
| ale_off | input | 1 | Suppress address latch strobe outside data cycles |
| fetch_req | input | 1 | Code fetch request |
| fetch_addr | input | 16 | Code fetch address |
| data_req | input | 1 | Data memory request |
| data_we | input | 1 | 1 = write, 0 = read |
| data_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit indirect |
| data_addr | input | 16 | Data address |
| data_wdata | input | 8 | Write data |
| p2_reg | input | 8 | High port register value |
| ad_in | input | 8 | Low port pad input |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Low port output value |
| ad_oe | output | 1 | Low port output enable (strong drive) |
| a_hi | output | 8 | High address port |
| fetch_acc | output | 1 | Fetch request accepted at next edge |
| data_acc | output | 1 | Data request accepted at next edge |
| fetch_done | output | 1 | Fetch completes at this cycle |
| data_done | output | 1 | Data access completes at this cycle |
| rdata | output | 1*8 | Read/fetch byte, valid with a done |
| code_internal | output | 1 | Current fetch served from internal memory |

## Verification
Accept pulses are combinational: they appear in the cycle whose closing edge enters slot 0 or 6. The bench finds that cycle and then counts strobe cycles in a window that starts on the very next cycle. The window is 12 clocks for one normal-rate data cycle and 6 for a fast-rate one. Fetch windows are 24 or 6 clocks and start right after an accept, so each pulse falls wholly inside the window. Done and `rdata` are combinational in the last strobe slot. The bench samples them on the falling edge of that same cycle, with inputs changed 1 ns after a rising edge.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
// Shared slot constants, cycle type and window decoders for the external
// bus sequencer. A machine cycle is twelve slots, split into two halves.
package ebus_pkg;
    typedef logic [3:0] slot_t;

    localparam slot_t S_HALF     = 4'd6;   // first slot of second half
    localparam slot_t S_LAST     = 4'd11;  // last slot of a machine cycle
    localparam slot_t ALE_LEN    = 4'd2;   // address strobe slots per half
    localparam slot_t PSEN_FIRST = 4'd2;   // program strobe start within half
    localparam slot_t RW_FIRST   = 4'd4;   // read/write strobe start
    localparam slot_t RW_STOP    = 4'd10;  // first slot after read/write strobe
    localparam int    SLOT_COUNT = 12;

    typedef enum logic [2:0] {
        CY_IDLE,
        CY_FETCH_INT,
        CY_FETCH_EXT,
        CY_DATA_RD,
        CY_DATA_WR
    } cyc_e;

    // Position of a slot inside its half machine cycle.
    function automatic slot_t half_pos(slot_t s);
        return (s >= S_HALF) ? s - S_HALF : s;
    endfunction

    function automatic logic in_ale_win(slot_t s);
        return half_pos(s) < ALE_LEN;
    endfunction

    function automatic logic in_psen_win(slot_t s);
        return half_pos(s) >= PSEN_FIRST;
    endfunction

    function automatic logic in_rw_win(slot_t s);
        return (s >= RW_FIRST) && (s < RW_STOP);
    endfunction
endpackage

// File: rtl/ebus_slot_timer.sv
`timescale 1ns/1ps
// Slot counter for one machine cycle. Assumes adv_en gates progress; in
// fast rate the counter visits only even slots, rounding an odd slot up.
module ebus_slot_timer
    import ebus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_en,
    input  logic  six_clk,
    output slot_t slot,
    output slot_t slot_nxt
);
    logic [4:0] raw_nxt;

    // Next slot: step one, or jump to the next even slot in fast rate.
    always_comb begin
        if (six_clk) raw_nxt = {1'b0, slot[3:1], 1'b0} + 5'd2;
        else         raw_nxt = {1'b0, slot} + 5'd1;
        slot_nxt = (raw_nxt >= 5'(SLOT_COUNT)) ? 4'd0 : raw_nxt[3:0];
    end

    // Slot register; rests in the final slot during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      slot <= S_LAST;
        else if (adv_en) slot <= slot_nxt;
    end

    // R11: after a fast-rate advance the counter sits on an even slot.
    a_r11_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(six_clk && adv_en)) |-> (slot[0] == 1'b0));

    // R13: the counter never leaves the twelve-slot range.
    a_r13_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= S_LAST);
endmodule

// File: rtl/ebus_arbiter.sv
`timescale 1ns/1ps
// Request acceptance and cycle state. Data requests start only at slot 0
// and own the whole machine cycle; fetches start at either half. The
// access-enable pin is captured during reset and then frozen.
module ebus_arbiter
    import ebus_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8,
    parameter int INT_CODE_BYTES = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_pin,
    input  logic              adv_en,
    input  slot_t             slot,
    input  slot_t             slot_nxt,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    output cyc_e              cyc,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              wide_q,
    output logic              fetch_acc,
    output logic              data_acc,
    output logic              fetch_done,
    output logic              data_done,
    output logic              code_internal
);
    localparam logic [ADDR_W:0] INT_LIMIT = (ADDR_W+1)'(INT_CODE_BYTES);

    logic ea_q;
    logic enter_top, enter_mid, data_busy, fetch_ext, fetch_busy;

    // Decision points and fetch routing.
    always_comb begin
        enter_top  = adv_en && (slot_nxt == 4'd0);
        enter_mid  = adv_en && (slot_nxt == S_HALF);
        data_busy  = (cyc == CY_DATA_RD) || (cyc == CY_DATA_WR);
        fetch_busy = (cyc == CY_FETCH_INT) || (cyc == CY_FETCH_EXT);
        fetch_ext  = !ea_q || !({1'b0, fetch_addr} < INT_LIMIT);
        data_acc   = enter_top && data_req;
        fetch_acc  = fetch_req &&
                     ((enter_top && !data_req) || (enter_mid && !data_busy));
    end

    // Completion at the edge that leaves the strobe window.
    always_comb begin
        fetch_done = adv_en && fetch_busy &&
                     in_psen_win(slot) && !in_psen_win(slot_nxt);
        data_done  = adv_en && data_busy &&
                     in_rw_win(slot) && !in_rw_win(slot_nxt);
        code_internal = (cyc == CY_FETCH_INT);
    end

    // Cycle state, request latches and reset-time pin capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q    <= ea_pin;
            cyc     <= CY_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            wide_q  <= 1'b0;
        end else if (data_acc) begin
            cyc     <= data_we ? CY_DATA_WR : CY_DATA_RD;
            addr_q  <= data_addr;
            wdata_q <= data_wdata;
            wide_q  <= data_wide;
        end else if (fetch_acc) begin
            cyc     <= fetch_ext ? CY_FETCH_EXT : CY_FETCH_INT;
            addr_q  <= fetch_addr;
            wide_q  <= 1'b1;
        end else if (enter_top || (enter_mid && !data_busy)) begin
            cyc     <= CY_IDLE;
        end
    end

    // R6: the captured access-enable never changes after reset release.
    a_r6_ea_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ea_q));

    // R12: an accepted data request owns the bus from slot 0.
    a_r12_data_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> (data_busy && slot == 4'd0));

    // R12: a data cycle is not replaced at the half-cycle point.
    a_r12_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (data_busy && enter_mid) |=> data_busy);

    // R3: at most one completion per cycle.
    a_r3_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_done, data_done}));
endmodule

// File: rtl/ebus_strobe_gen.sv
`timescale 1ns/1ps
// Strobe and port decode from the slot and the current cycle type.
// Purely combinational; assumes the arbiter holds cyc for its window.
module ebus_strobe_gen
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  slot_t             slot,
    input  cyc_e              cyc,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              wide_q,
    input  logic [HI_W-1:0]   p2_reg,
    input  logic              ale_off,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi
);
    logic is_data, is_fext, addr_phase, top_ale;

    // Strobe windows, skip rules and port sources.
    always_comb begin
        is_data    = (cyc == CY_DATA_RD) || (cyc == CY_DATA_WR);
        is_fext    = (cyc == CY_FETCH_EXT);
        top_ale    = slot < ALE_LEN;
        if (ale_off) ale = is_data && top_ale;
        else         ale = in_ale_win(slot) && !(is_data && slot >= S_HALF);
        psen_n     = !(is_fext && in_psen_win(slot));
        rd_n       = !((cyc == CY_DATA_RD) && in_rw_win(slot));
        wr_n       = !((cyc == CY_DATA_WR) && in_rw_win(slot));
        addr_phase = (is_fext && in_ale_win(slot)) || (is_data && top_ale);
        ad_oe      = addr_phase || ((cyc == CY_DATA_WR) && slot >= ALE_LEN);
        ad_out     = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
        if (is_fext || (is_data && wide_q)) a_hi = addr_q[ADDR_W-1:DATA_W];
        else                                a_hi = p2_reg;
    end
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
// External memory bus cycle sequencer top. Connects the slot counter, the
// request arbiter and the strobe decode; read data passes straight from
// the low port pads and is valid while a done is high.
module ebus_seq
    import ebus_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int DATA_W         = 8,
    parameter int INT_CODE_BYTES = 8192,
    localparam int HI_W          = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_pin,
    input  logic              adv_en,
    input  logic              six_clk,
    input  logic              ale_off,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_req,
    input  logic              data_we,
    input  logic              data_wide,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic [HI_W-1:0]   p2_reg,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   a_hi,
    output logic              fetch_acc,
    output logic              data_acc,
    output logic              fetch_done,
    output logic              data_done,
    output logic [DATA_W-1:0] rdata,
    output logic              code_internal
);
    slot_t             slot, slot_nxt;
    cyc_e              cyc;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wide_q;

    ebus_slot_timer u_timer (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .six_clk(six_clk),
        .slot(slot), .slot_nxt(slot_nxt)
    );

    ebus_arbiter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_CODE_BYTES(INT_CODE_BYTES)
    ) u_arb (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .adv_en(adv_en),
        .slot(slot), .slot_nxt(slot_nxt),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_we(data_we), .data_wide(data_wide),
        .data_addr(data_addr), .data_wdata(data_wdata),
        .cyc(cyc), .addr_q(addr_q), .wdata_q(wdata_q), .wide_q(wide_q),
        .fetch_acc(fetch_acc), .data_acc(data_acc),
        .fetch_done(fetch_done), .data_done(data_done),
        .code_internal(code_internal)
    );

    ebus_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .slot(slot), .cyc(cyc), .addr_q(addr_q), .wdata_q(wdata_q),
        .wide_q(wide_q), .p2_reg(p2_reg), .ale_off(ale_off),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi)
    );

    // Read data is taken from the pads in the completing cycle.
    assign rdata = ad_in;

    // R1: the address strobe only starts at a half-cycle boundary.
    a_r1_ale_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> (slot == 4'd0 || slot == S_HALF));

    // R2: program strobe never overlaps a data strobe.
    a_r2_psen_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> (rd_n && wr_n));

    // R8: read and write strobes are never both active.
    a_r8_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R10: the low port is released while a read strobe is active.
    a_r10_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R4: an internal fetch never pulses the program strobe.
    a_r4_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        code_internal |-> psen_n);
endmodule

// File: tb/ebus_seq_tb.sv
`timescale 1ns/1ps
module ebus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ea_pin = 1'b0, adv_en = 1'b1, six_clk = 1'b0, ale_off = 1'b0;
    logic        fetch_req = 1'b0, data_req = 1'b0, data_we = 1'b0, data_wide = 1'b0;
    logic [15:0] fetch_addr = '0, data_addr = '0;
    logic [7:0]  data_wdata = '0, p2_reg = '0, ad_in = '0;
    logic        ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  ad_out, a_hi, rdata;
    logic        fetch_acc, data_acc, fetch_done, data_done, code_internal;

    int errs = 0, checks = 0;
    int n_ale, n_ale_rise, n_psen, n_psen_fall, n_rd, n_wr, n_fd, n_dd;
    int n_bad_rd, n_bad_hi, n_addr, n_bad_lo, n_wd_ok, n_rd_oe, n_int;
    logic prev_ale, prev_psen;
    logic [7:0] exp_rd, exp_hi, exp_lo, exp_wd;

    always #2.5 clk = ~clk;

    ebus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ea_pin(ea_pin), .adv_en(adv_en),
        .six_clk(six_clk), .ale_off(ale_off), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .data_req(data_req), .data_we(data_we),
        .data_wide(data_wide), .data_addr(data_addr), .data_wdata(data_wdata),
        .p2_reg(p2_reg), .ad_in(ad_in), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .fetch_acc(fetch_acc), .data_acc(data_acc),
        .fetch_done(fetch_done), .data_done(data_done), .rdata(rdata),
        .code_internal(code_internal)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic zero_counts();
        n_ale = 0; n_ale_rise = 0; n_psen = 0; n_psen_fall = 0; n_rd = 0;
        n_wr = 0; n_fd = 0; n_dd = 0; n_bad_rd = 0; n_bad_hi = 0; n_addr = 0;
        n_bad_lo = 0; n_wd_ok = 0; n_rd_oe = 0; n_int = 0;
        prev_ale = ale; prev_psen = psen_n;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        zero_counts();
    endtask

    task automatic observe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ale) n_ale++;
            if (ale && !prev_ale) n_ale_rise++;
            if (!psen_n) n_psen++;
            if (!psen_n && prev_psen) n_psen_fall++;
            if (!rd_n) n_rd++;
            if (!wr_n) n_wr++;
            if (fetch_done) n_fd++;
            if (data_done) n_dd++;
            if ((fetch_done || (data_done && wr_n)) && rdata != exp_rd) n_bad_rd++;
            if ((!psen_n || !rd_n || !wr_n) && a_hi != exp_hi) n_bad_hi++;
            if (ale && ad_oe) begin
                n_addr++;
                if (ad_out != exp_lo) n_bad_lo++;
            end
            if (!wr_n && ad_oe && ad_out == exp_wd) n_wd_ok++;
            if (!rd_n && ad_oe) n_rd_oe++;
            if (code_internal) n_int++;
            prev_ale = ale; prev_psen = psen_n;
        end
    endtask

    // Returns at the negedge where the requested accept is high.
    task automatic wait_acc(input bit want_data, output bit other);
        other = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (want_data ? data_acc : fetch_acc) begin
                other = want_data ? fetch_acc : data_acc;
                break;
            end
        end
        zero_counts();
    endtask

    task automatic do_reset(input logic ea);
        ea_pin = ea;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        bit other;
        // R13 reset state
        do_reset(1'b0);
        @(negedge clk);
        check("R13 ale", ale, 0);
        check("R13 strobes", {psen_n, rd_n, wr_n}, 7);
        check("R13 ad_oe", ad_oe, 0);
        check("R13 done", {fetch_done, data_done}, 0);

        // R1 idle address strobe
        clear_mon(); observe(24);
        check("R1 ale high cycles", n_ale, 8);
        check("R1 ale pulses", n_ale_rise, 4);
        check("R1 psen idle", n_psen, 0);

        // R3 R5 R9 R10 continuous external fetch, enable latched low
        fetch_addr = 16'h1234; ad_in = 8'hA7;
        exp_rd = 8'hA7; exp_hi = 8'h12; exp_lo = 8'h34;
        fetch_req = 1'b1;
        wait_acc(1'b0, other); observe(24);
        check("R3 psen low cycles", n_psen, 16);
        check("R3 psen pulses", n_psen_fall, 4);
        check("R3 fetch done", n_fd, 4);
        check("R3 rdata", n_bad_rd, 0);
        check("R5 low address goes external", n_int, 0);
        check("R9 fetch high byte", n_bad_hi, 0);
        check("R10 address phases", n_addr, 8);
        check("R10 address byte", n_bad_lo, 0);
        fetch_req = 1'b0;

        // R4 R6 internal fetch with enable latched high
        do_reset(1'b1);
        fetch_addr = 16'h1FFF; fetch_req = 1'b1;
        wait_acc(1'b0, other); observe(6);
        check("R4 internal psen", n_psen, 0);
        check("R4 internal flag", n_int, 6);
        check("R4 internal done", n_fd, 1);
        ea_pin = 1'b0;
        wait_acc(1'b0, other); observe(6);
        check("R6 pin change ignored", n_psen, 0);
        fetch_addr = 16'h2000; exp_hi = 8'h20; exp_rd = 8'hA7;
        wait_acc(1'b0, other); observe(6);
        check("R4 boundary external psen", n_psen, 4);
        check("R4 boundary flag", n_int, 0);
        check("R9 boundary high byte", n_bad_hi, 0);

        // R2 R8 R9 R12 wide data read with competing fetch
        data_addr = 16'hBEEF; data_wide = 1'b1; data_we = 1'b0;
        ad_in = 8'h5A; exp_rd = 8'h5A; exp_hi = 8'hBE; exp_lo = 8'hEF;
        data_req = 1'b1;
        wait_acc(1'b1, other);
        check("R12 data wins over fetch", other, 0);
        @(posedge clk); #1 data_req = 1'b0; fetch_req = 1'b0;
        observe(12);
        check("R2 single ale", n_ale_rise, 1);
        check("R2 ale cycles", n_ale, 2);
        check("R2 psen quiet", n_psen, 0);
        check("R8 read strobe", n_rd, 6);
        check("R8 data done", n_dd, 1);
        check("R8 read data", n_bad_rd, 0);
        check("R9 wide high byte", n_bad_hi, 0);
        check("R10 read released", n_rd_oe, 0);
        check("R10 data address", n_bad_lo, 0);

        // R8 R9 R10 narrow data write
        data_addr = 16'h0077; data_wide = 1'b0; data_we = 1'b1;
        data_wdata = 8'hC3; p2_reg = 8'h3C;
        exp_hi = 8'h3C; exp_lo = 8'h77; exp_wd = 8'hC3;
        data_req = 1'b1;
        wait_acc(1'b1, other);
        @(posedge clk); #1 data_req = 1'b0;
        observe(12);
        check("R8 write strobe", n_wr, 6);
        check("R8 write done", n_dd, 1);
        check("R9 narrow uses p2", n_bad_hi, 0);
        check("R10 write data driven", n_wd_ok, 6);

        // R7 address strobe suppression
        ale_off = 1'b1;
        clear_mon(); observe(24);
        check("R7 idle ale suppressed", n_ale, 0);
        data_we = 1'b0; data_req = 1'b1;
        wait_acc(1'b1, other);
        @(posedge clk); #1 data_req = 1'b0;
        observe(12);
        check("R7 data ale kept", n_ale, 2);
        ale_off = 1'b0;

        // R11 fast rate
        six_clk = 1'b1;
        observe(2);
        clear_mon(); observe(12);
        check("R11 ale cycles", n_ale, 4);
        check("R11 ale pulses", n_ale_rise, 4);
        data_wide = 1'b1; data_addr = 16'hBEEF; exp_hi = 8'hBE; exp_rd = 8'h5A;
        data_req = 1'b1;
        wait_acc(1'b1, other);
        @(posedge clk); #1 data_req = 1'b0;
        observe(6);
        check("R11 read strobe", n_rd, 3);
        check("R11 single ale", n_ale, 1);
        check("R11 data done", n_dd, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule